// File: doc/BRIEF.md
# Non-Preemptive DMA Channel Bus Arbiter

This block shares one system bus among four DMA channels: a receive and a transmit channel for each of two serial links. Each channel raises a request line while it has data to move. The arbiter asks the host for the bus with a request/acknowledge handshake. Once the host acknowledges, it grants the bus to one channel at a time, picking channels in a programmable rank order.

A channel that holds the grant keeps it until it drops its own request. A higher-ranked request that arrives in the meantime waits. In the default mode the arbiter keeps the bus and hands it straight to the next pending channel. In per-channel mode it gives the bus back after every service and asks for it again. The rank table is captured only while no channel is being served, so software may rewrite it at any time without disturbing a transfer that is in progress.

Top module: `dma_bus_arbiter`

## Requirements
- R1: At most one grant bit is high in any cycle, and a grant is high only while both `bus_req` and `bus_ack` are high.
- R2: While reset is asserted, `bus_req` and every grant bit are low.
- R3: From idle, with `bus_ack` low and any request high, `bus_req` rises at the next edge. At the first edge where `bus_ack` is sampled high with requests pending, the grant goes to the requesting channel with the best rank. `prio_order[2*k +: 2]` holds the channel index of rank k, and rank 0 is the best.
- R4: While the granted channel keeps its request high, its grant stays unchanged, even when better-ranked requests arrive.
- R5: When the granted channel's request is sampled low, its grant is low after that same edge.
- R6: With `per_chan_mode` low, if other requests are pending when a service ends, `bus_req` stays high. The next grant is issued one edge after the previous grant clears.
- R7: When a service ends with no other request pending, `bus_req` falls at the same edge at which the grant clears.
- R8: With `per_chan_mode` high, `bus_req` falls at the edge at which a service ends. It is not raised again while `bus_ack` is still high.
- R9: A grant uses the `prio_order` value sampled at the last edge at which no service was running. Changes made during a service do not affect the choice that follows that service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 4 | Per-channel service request |
| prio_order | input | 8 | Rank table: 2-bit channel index per rank, rank 0 in bits [1:0] |
| per_chan_mode | input | 1 | 1: release the bus after each channel service |
| bus_ack | input | 1 | Host acknowledges bus ownership |
| bus_req | output | 1 | Bus request to the host |
| chan_gnt | output | 4 | One-hot grant to the channel being served |

## Verification
The bench first serves a low-ranked channel and raises better-ranked requests while it runs. A design that preempted would move the grant before the owner drops its request. During that same service the rank table is rewritten. A design that arbitrated with the live table would pick the newly favoured channel instead of the one from the captured table. In per-channel mode the host model holds its acknowledge high for several cycles after the request falls; a design that re-requested early would raise `bus_req` during that window. Random request, mode and table traffic with random acknowledge latency is checked cycle by cycle against a reference model. This catches wrong hand-over gaps and requests that stay high after the last service.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ASK   = 2'd1,
    ST_SERVE = 2'd2,
    ST_DROP  = 2'd3
  } arb_state_e;
endpackage

// File: rtl/dma_arb_pick.sv
// Combinational rank search: the lowest rank slot whose channel requests wins.
module dma_arb_pick #(
  parameter int NCH = 4,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH*IW-1:0] order,
  input  logic [NCH-1:0]    req,
  output logic              found,
  output logic [NCH-1:0]    win_oh
);
  always_comb begin
    found  = 1'b0;
    win_oh = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (req[order[k*IW +: IW]]) begin
        found = 1'b1;
        win_oh = '0;
        win_oh[order[k*IW +: IW]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_cfg.sv
// Rank table snapshot, one register per rank slot, loaded only when enabled.
module dma_arb_cfg #(
  parameter int NCH = 4,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [NCH*IW-1:0] order_in,
  output logic [NCH*IW-1:0] order_q
);
  for (genvar s = 0; s < NCH; s++) begin : g_slot
    logic [IW-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= IW'(s);
      end else if (load_en) begin
        slot_q <= order_in[s*IW +: IW];
      end
    end
    assign order_q[s*IW +: IW] = slot_q;
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_req,
  input  logic [NCH*IW-1:0] prio_order,
  input  logic              per_chan_mode,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic [NCH-1:0]    chan_gnt
);
  arb_state_e        state_q, state_d;
  logic [NCH-1:0]    gnt_q, gnt_d;
  logic [NCH*IW-1:0] order_q;
  logic              cfg_load;
  logic              win_found;
  logic [NCH-1:0]    win_oh;
  logic              owner_live;
  logic              others_wait;

  // Rank table is frozen for the whole of a service.
  assign cfg_load = (state_q != ST_SERVE);

  dma_arb_cfg #(.NCH(NCH), .IW(IW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (cfg_load),
    .order_in (prio_order),
    .order_q  (order_q)
  );

  dma_arb_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .order  (order_q),
    .req    (chan_req),
    .found  (win_found),
    .win_oh (win_oh)
  );

  assign owner_live  = |(chan_req & gnt_q);
  assign others_wait = |(chan_req & ~gnt_q);

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if ((|chan_req) && !bus_ack) state_d = ST_ASK;
      end
      ST_ASK: begin
        if (bus_ack) begin
          if (win_found) begin
            gnt_d   = win_oh;
            state_d = ST_SERVE;
          end else begin
            state_d = ST_DROP;
          end
        end
      end
      ST_SERVE: begin
        if (!owner_live) begin
          gnt_d = '0;
          if (!per_chan_mode && others_wait) state_d = ST_ASK;
          else                               state_d = ST_DROP;
        end
      end
      ST_DROP: begin
        if (!bus_ack) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        gnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
    end else begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
    end
  end

  assign bus_req  = (state_q == ST_ASK) || (state_q == ST_SERVE);
  assign chan_gnt = gnt_q;

  // R1: single grant, and only with the bus owned
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt));
  a_r1_grant_owns_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_gnt != '0) |-> (bus_req && bus_ack));
  // R4: no preemption while owner still requests
  a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt & chan_req) != '0) |=> (chan_gnt == $past(chan_gnt)));
  // R5: grant clears once owner request is seen low
  a_r5_end_service: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt != '0) && ((chan_gnt & chan_req) == '0)) |=> (chan_gnt == '0));
  // R7: nothing left pending, bus is let go
  a_r7_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_gnt != '0) && (chan_req == '0)) |=> !bus_req);
  // R8: per-channel release and no early re-request
  a_r8_per_release: assert property (@(posedge clk) disable iff (!rst_n)
    (per_chan_mode && (chan_gnt != '0) && ((chan_gnt & chan_req) == '0)) |=> !bus_req);
  a_r8_wait_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_ack) |=> !bus_req);
  // R9: rank table untouched while a service runs
  a_r9_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SERVE) |=> $stable(order_q));
endmodule

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = 4'b0;
  logic [7:0] prio = 8'b11_10_01_00;
  logic       per_mode = 1'b0;
  logic       bus_ack = 1'b0;
  wire        bus_req;
  wire  [3:0] gnt;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int ack_dly = 0;
  int ack_cnt = 0;
  bit done = 0;

  // reference model state (0 idle, 1 ask, 2 serve, 3 drop)
  int         m_state = 0;
  logic [3:0] m_gnt = 4'b0;
  logic [7:0] m_prio = 8'b11_10_01_00;

  always #5 clk = ~clk;

  dma_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .chan_req(req), .prio_order(prio),
    .per_chan_mode(per_mode), .bus_ack(bus_ack), .bus_req(bus_req), .chan_gnt(gnt)
  );

  function automatic logic [3:0] pick(input logic [3:0] r, input logic [7:0] ord);
    for (int k = 0; k < 4; k++) begin
      if (r[ord[2*k +: 2]]) return 4'b1 << ord[2*k +: 2];
    end
    return 4'b0;
  endfunction

  function automatic logic [7:0] rand_perm();
    int a [4];
    logic [7:0] v;
    for (int i = 0; i < 4; i++) a[i] = i;
    for (int i = 3; i > 0; i--) begin
      int j = $urandom % (i + 1);
      int t = a[i];
      a[i] = a[j];
      a[j] = t;
    end
    for (int i = 0; i < 4; i++) v[2*i +: 2] = a[i][1:0];
    return v;
  endfunction

  always @(posedge clk) begin
    logic [7:0] p_old;
    if (!rst_n) begin
      m_state = 0; m_gnt = 4'b0; m_prio = 8'b11_10_01_00;
    end else begin
      p_old = m_prio;
      if (m_state != 2) m_prio = prio;
      case (m_state)
        0: if (req != 0 && !bus_ack) m_state = 1;
        1: if (bus_ack) begin
             if (req != 0) begin m_gnt = pick(req, p_old); m_state = 2; end
             else m_state = 3;
           end
        2: if ((req & m_gnt) == 0) begin
             if (!per_mode && (req & ~m_gnt) != 0) m_state = 1;
             else m_state = 3;
             m_gnt = 4'b0;
           end
        default: if (!bus_ack) m_state = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic exp_breq;
    @(negedge clk);
    exp_breq = (m_state == 1 || m_state == 2);
    check(gnt === m_gnt, "R4 grant vs model", gnt, m_gnt);
    check(bus_req === exp_breq, "R6 bus_req vs model", bus_req, exp_breq);
    check($onehot0(gnt) && (gnt == 0 || (bus_req && bus_ack)), "R1 grant legality", gnt, {bus_req, bus_ack});
    if (bus_ack != bus_req) begin
      if (ack_cnt >= ack_dly) begin bus_ack = bus_req; ack_cnt = 0; end
      else ack_cnt++;
    end else ack_cnt = 0;
  endtask

  task automatic wait_gnt();
    for (int i = 0; i < 40; i++) begin
      if (gnt != 0) return;
      tick();
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      done = 1;
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(bus_req === 1'b0 && gnt === 4'b0, "R2 reset outputs", {bus_req, gnt}, 0);
    rst_n = 1'b1;
    ack_dly = 2;
    prio = 8'b01_11_00_10;          // ranks: ch2, ch0, ch3, ch1
    repeat (2) tick();

    // R3 lone low-ranked request is granted
    req = 4'b0010;
    wait_gnt();
    check(gnt === 4'b0010, "R3 first grant", gnt, 4'b0010);
    // R4 better-ranked requests arrive; R9 table rewritten mid-service
    req = 4'b0111;
    prio = 8'b01_11_10_00;          // ranks: ch0, ch2, ch3, ch1
    for (int i = 0; i < 5; i++) begin
      tick();
      check(gnt === 4'b0010, "R4 owner kept", gnt, 4'b0010);
    end
    req = 4'b0101;
    tick();
    check(gnt === 4'b0000, "R5 grant cleared", gnt, 0);
    check(bus_req === 1'b1, "R6 bus kept", bus_req, 1);
    tick();
    check(gnt === 4'b0100, "R9 captured table used", gnt, 4'b0100);
    req = 4'b0001;
    tick();
    check(gnt === 4'b0000 && bus_req === 1'b1, "R6 gap with bus held", {bus_req, gnt}, 5'h10);
    tick();
    check(gnt === 4'b0001, "R6 next grant", gnt, 4'b0001);
    req = 4'b0000;
    tick();
    check(gnt === 4'b0000 && bus_req === 1'b0, "R7 release when empty", {bus_req, gnt}, 0);
    repeat (6) tick();

    // per-channel mode
    per_mode = 1'b1;
    req = 4'b1001;
    wait_gnt();
    check(gnt === 4'b0001, "R3 rank pick", gnt, 4'b0001);
    repeat (2) tick();
    req = 4'b1000;
    tick();
    check(gnt === 4'b0000 && bus_req === 1'b0, "R8 release per channel", {bus_req, gnt}, 0);
    for (int i = 0; i < 20; i++) begin
      if (!bus_ack) break;
      check(bus_req === 1'b0, "R8 no re-request while ack high", bus_req, 0);
      tick();
    end
    wait_gnt();
    check(gnt === 4'b1000, "R8 re-request then grant", gnt, 4'b1000);
    req = 4'b0000;
    repeat (8) tick();

    // random traffic
    per_mode = 1'b0;
    for (int n = 0; n < 5000; n++) begin
      if ($urandom % 300 == 0) per_mode = ~per_mode;
      if ($urandom % 150 == 0) prio = rand_perm();
      if (bus_ack == bus_req) ack_dly = $urandom % 4;
      for (int i = 0; i < 4; i++) begin
        if (req[i] && gnt[i] && ($urandom % 4 == 0)) req[i] = 1'b0;
        else if (!req[i] && !gnt[i] && ($urandom % 6 == 0)) req[i] = 1'b1;
      end
      tick();
    end
    done = 1;
    finish_up();
  end
endmodule